// File: doc/BRIEF.md
# Register Status and Rename Table

This block holds the architectural register state of a small out-of-order execution core. Each of its four registers keeps a 32-bit data word, a busy flag and the tag of the reservation station that will produce its next value. At dispatch, two source lookups return either a ready value or the producer tag to wait on. In the same cycle, one destination register can be renamed to the dispatching station's tag.

The block also snoops a single result broadcast bus that carries a tag and a value. A register takes a broadcast only when it is still waiting on that exact tag. A later writer to the same register replaces the earlier producer tag, so an earlier, superseded result never overwrites the newer one. Write-after-write ordering is therefore kept without a stall. Lookups made in the same cycle as a matching broadcast receive the broadcast value directly.

Top module: `regstat_table`

## Requirements
- R1: A synchronous active-high reset clears every busy flag and tag and loads each register with its value from the `INIT_VALS` parameter. Register k takes bits [32k+31:32k], where register index 0..3 maps to addresses 0, 2, 4, 8.
- R2: A lookup of a mapped address whose register is not busy returns the stored value with tag 0.
- R3: A lookup of a busy register returns its producer tag (never 0) with the value field driven to 0.
- R4: A dispatch with `dst_en`=1, a mapped `dst_addr` and a nonzero `dst_tag` makes the register busy with that tag from the next cycle.
- R5: A dispatch to a register that is already busy replaces the stored tag, and later lookups return the new tag.
- R6: A valid broadcast whose nonzero tag equals a busy register's stored tag writes the broadcast value into that register and clears its busy flag and tag on the next cycle.
- R7: A broadcast whose tag matches no busy register's current tag, including the tag of a superseded producer, leaves all registers unchanged.
- R8: When a dispatch and a matching broadcast hit the same register in one cycle, the dispatch wins. The register stays busy with the new tag and keeps its old value.
- R9: A lookup made in the same cycle as a broadcast matching that register's tag returns the broadcast value with tag 0.
- R10: Addresses other than 0, 2, 4 and 8 are ignored. A dispatch to one changes no register, and a lookup of one returns value 0 with tag 0.
- R11: A dispatch carrying tag 0, or a broadcast with `bc_valid`=0 or tag 0, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_addr | input | 4 | First source register address |
| src_a_val | output | 32 | First source value (0 when a tag is returned) |
| src_a_tag | output | 4 | First source producer tag, 0 when the value is ready |
| src_b_addr | input | 4 | Second source register address |
| src_b_val | output | 32 | Second source value |
| src_b_tag | output | 4 | Second source producer tag |
| dst_en | input | 1 | Destination rename request |
| dst_addr | input | 4 | Destination register address |
| dst_tag | input | 4 | Tag of the dispatching station |
| bc_valid | input | 1 | Broadcast bus valid |
| bc_tag | input | 4 | Broadcast producer tag |
| bc_val | input | 32 | Broadcast result value |

## Verification
Directed sequences recreate the three hazard cases: a read waiting on a pending write, a register renamed twice followed by the stale producer's broadcast, and a rename colliding with the matching broadcast in one cycle. These separate correct tag replacement from ordering that lets the last broadcast win. A long pseudo-random sweep then draws every 4-bit address, including unmapped ones, along with zero and nonzero tags. Its broadcast tags are biased toward tags that are currently live. Every lookup in every cycle is compared against an arithmetic model in the bench, which exposes forwarding, capture and hold errors.

// File: rtl/regstat_pkg.sv
package regstat_pkg;
   // Architectural address of register index i: 0, 2, 4, 8, ...
   function automatic int reg_addr(input int i);
      return (i == 0) ? 0 : (1 << i);
   endfunction
endpackage

// File: rtl/regstat_entry.sv
module regstat_entry #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 4,
   parameter logic [DATA_W-1:0] INIT = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              set_en,
   input  logic [TAG_W-1:0]  set_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              busy_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic [DATA_W-1:0] val_o
);
   logic              busy_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] val_q;
   logic              match;

   assign match = busy_q && bc_valid && (bc_tag != '0) && (bc_tag == tag_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         tag_q  <= '0;
         val_q  <= INIT;
      end else if (set_en) begin
         busy_q <= 1'b1;
         tag_q  <= set_tag;
      end else if (match) begin
         busy_q <= 1'b0;
         tag_q  <= '0;
         val_q  <= bc_val;
      end
   end

   assign busy_o = busy_q;
   assign tag_o  = tag_q;
   assign val_o  = val_q;

   // R4
   rename_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
      set_en |=> (busy_q && tag_q == $past(set_tag)));
   // R8
   rename_keeps_val_chk: assert property (@(posedge clk) disable iff (rst)
      set_en |=> $stable(val_q));
   // R6
   capture_chk: assert property (@(posedge clk) disable iff (rst)
      (!set_en && match) |=> (!busy_q && tag_q == '0 && val_q == $past(bc_val)));
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!set_en && !match) |=> ($stable(busy_q) && $stable(tag_q) && $stable(val_q)));
   // R3
   busy_tag_chk: assert property (@(posedge clk) disable iff (rst)
      busy_q == (tag_q != '0));
endmodule

// File: rtl/regstat_lookup.sv
module regstat_lookup #(
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 4,
   parameter int ADDR_W   = 4,
   parameter int NUM_REGS = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NUM_REGS-1:0]        busy,
   input  logic [NUM_REGS*TAG_W-1:0]  tags,
   input  logic [NUM_REGS*DATA_W-1:0] vals,
   input  logic                       bc_valid,
   input  logic [TAG_W-1:0]           bc_tag,
   input  logic [DATA_W-1:0]          bc_val,
   output logic [DATA_W-1:0]          val_o,
   output logic [TAG_W-1:0]           tag_o
);
   logic mapped;

   always_comb begin
      val_o  = '0;
      tag_o  = '0;
      mapped = 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr == ADDR_W'(regstat_pkg::reg_addr(i))) begin
            mapped = 1'b1;
            if (!busy[i]) begin
               val_o = vals[i*DATA_W +: DATA_W];
            end else if (bc_valid && bc_tag != '0 && bc_tag == tags[i*TAG_W +: TAG_W]) begin
               val_o = bc_val;
            end else begin
               tag_o = tags[i*TAG_W +: TAG_W];
            end
         end
      end
   end

   // R3
   wait_val_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (tag_o != '0) |-> (val_o == '0));
   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !mapped |-> (val_o == '0 && tag_o == '0));
endmodule

// File: rtl/regstat_table.sv
module regstat_table #(
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 4,
   parameter int ADDR_W   = 4,
   parameter int NUM_REGS = 4,
   parameter logic [NUM_REGS*DATA_W-1:0] INIT_VALS = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] src_a_addr,
   output logic [DATA_W-1:0] src_a_val,
   output logic [TAG_W-1:0]  src_a_tag,
   input  logic [ADDR_W-1:0] src_b_addr,
   output logic [DATA_W-1:0] src_b_val,
   output logic [TAG_W-1:0]  src_b_tag,
   input  logic              dst_en,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [TAG_W-1:0]  dst_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val
);
   localparam int FLAT_T = NUM_REGS * TAG_W;
   localparam int FLAT_D = NUM_REGS * DATA_W;

   generate
      if (NUM_REGS < 1 || NUM_REGS > ADDR_W) begin : g_bad_regs
         $error("NUM_REGS must lie in 1..ADDR_W");
      end
      if (TAG_W < 2) begin : g_bad_tag
         $error("TAG_W must be at least 2");
      end
   endgenerate

   logic [NUM_REGS-1:0] busy;
   logic [NUM_REGS-1:0] set_sel;
   logic [FLAT_T-1:0]   tags;
   logic [FLAT_D-1:0]   vals;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      assign set_sel[i] = dst_en && (dst_tag != '0) &&
                          (dst_addr == ADDR_W'(regstat_pkg::reg_addr(i)));
      regstat_entry #(
         .DATA_W (DATA_W),
         .TAG_W  (TAG_W),
         .INIT   (INIT_VALS[i*DATA_W +: DATA_W])
      ) entry_i (
         .clk      (clk),
         .rst      (rst),
         .set_en   (set_sel[i]),
         .set_tag  (dst_tag),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_val   (bc_val),
         .busy_o   (busy[i]),
         .tag_o    (tags[i*TAG_W +: TAG_W]),
         .val_o    (vals[i*DATA_W +: DATA_W])
      );
   end

   regstat_lookup #(.DATA_W(DATA_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS))
   look_a_i (
      .clk(clk), .rst(rst), .addr(src_a_addr), .busy(busy), .tags(tags), .vals(vals),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .val_o(src_a_val), .tag_o(src_a_tag)
   );

   regstat_lookup #(.DATA_W(DATA_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS))
   look_b_i (
      .clk(clk), .rst(rst), .addr(src_b_addr), .busy(busy), .tags(tags), .vals(vals),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .val_o(src_b_val), .tag_o(src_b_tag)
   );

   // R11
   zero_tag_rename_chk: assert property (@(posedge clk) disable iff (rst)
      (dst_en && dst_tag == '0) |-> (set_sel == '0));
   // R10
   single_rename_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(set_sel));
endmodule

// File: tb/regstat_table_tb_top.sv
module regstat_table_tb_top;
   localparam logic [127:0] INITV = {32'hC0DE_0008, 32'hC0DE_0004, 32'hC0DE_0002, 32'hC0DE_0000};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [3:0]  a_addr = '0, b_addr = '0, d_addr = '0, d_tag = '0, c_tag = '0;
   logic        d_en = 1'b0, c_valid = 1'b0;
   logic [31:0] c_val = '0;
   logic [31:0] a_val, b_val;
   logic [3:0]  a_tag, b_tag;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_val [4];
   logic        m_busy [4];
   logic [3:0]  m_tag [4];

   always #4 clk = ~clk;

   regstat_table #(.INIT_VALS(INITV)) dut_i (
      .clk(clk), .rst(rst),
      .src_a_addr(a_addr), .src_a_val(a_val), .src_a_tag(a_tag),
      .src_b_addr(b_addr), .src_b_val(b_val), .src_b_tag(b_tag),
      .dst_en(d_en), .dst_addr(d_addr), .dst_tag(d_tag),
      .bc_valid(c_valid), .bc_tag(c_tag), .bc_val(c_val)
   );

   function automatic int idx_of(input logic [3:0] ad);
      case (ad)
         4'd0: return 0;
         4'd2: return 1;
         4'd4: return 2;
         4'd8: return 3;
         default: return -1;
      endcase
   endfunction

   function automatic logic [35:0] expect_look(input logic [3:0] ad);
      int k;
      k = idx_of(ad);
      if (k < 0) return 36'h0;
      if (!m_busy[k]) return {4'h0, m_val[k]};
      if (c_valid && c_tag != 0 && c_tag == m_tag[k]) return {4'h0, c_val};
      return {m_tag[k], 32'h0};
   endfunction

   task automatic check_port(input string lbl, input logic [3:0] ad,
                             input logic [31:0] v, input logic [3:0] t);
      logic [35:0] e;
      e = expect_look(ad);
      checks++;
      if ({t, v} !== e) begin
         errors++;
         $display("FAIL %s addr=%0d actual tag=%0d val=%h expected tag=%0d val=%h",
                  lbl, ad, t, v, e[35:32], e[31:0]);
      end
   endtask

   task automatic model_update();
      int k;
      k = idx_of(d_addr);
      for (int i = 0; i < 4; i++) begin
         if (d_en && d_tag != 0 && k == i) begin
            m_busy[i] = 1'b1;
            m_tag[i]  = d_tag;
         end else if (m_busy[i] && c_valid && c_tag != 0 && c_tag == m_tag[i]) begin
            m_busy[i] = 1'b0;
            m_tag[i]  = 4'h0;
            m_val[i]  = c_val;
         end
      end
   endtask

   // Called just after a negedge: drive, check lookups mid-phase, clock, update model.
   task automatic step(input string lbl, input logic [3:0] sa, input logic [3:0] sb,
                       input logic de, input logic [3:0] da, input logic [3:0] dt,
                       input logic cv, input logic [3:0] ct, input logic [31:0] cval);
      a_addr = sa; b_addr = sb; d_en = de; d_addr = da; d_tag = dt;
      c_valid = cv; c_tag = ct; c_val = cval;
      #1;
      check_port(lbl, a_addr, a_val, a_tag);
      check_port(lbl, b_addr, b_val, b_tag);
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_val[i] = INITV[i*32 +: 32]; m_busy[i] = 1'b0; m_tag[i] = 4'h0;
      end
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state on all four registers
      step("R1", 4'd0, 4'd2, 0, 0, 0, 0, 0, 0);
      step("R1", 4'd4, 4'd8, 0, 0, 0, 0, 0, 0);
      // R4 rename r2 to tag 1, then R3 lookup returns tag
      step("R4", 4'd2, 4'd0, 1, 4'd2, 4'd1, 0, 0, 0);
      step("R3", 4'd2, 4'd2, 0, 0, 0, 0, 0, 0);
      // R5 rename r2 again to tag 7
      step("R5", 4'd2, 4'd4, 1, 4'd2, 4'd7, 0, 0, 0);
      step("R5", 4'd2, 4'd0, 0, 0, 0, 0, 0, 0);
      // R7 superseded producer broadcasts: no change
      step("R7", 4'd2, 4'd0, 0, 0, 0, 1, 4'd1, 32'h1111_1111);
      step("R7", 4'd2, 4'd2, 0, 0, 0, 0, 0, 0);
      // R9 forwarding in same cycle, R6 capture afterwards
      step("R9", 4'd2, 4'd8, 0, 0, 0, 1, 4'd7, 32'h7777_7777);
      step("R6", 4'd2, 4'd2, 0, 0, 0, 0, 0, 0);
      // R8 rename and matching broadcast collide on r4
      step("R8", 4'd4, 4'd0, 1, 4'd4, 4'd3, 0, 0, 0);
      step("R8", 4'd4, 4'd4, 1, 4'd4, 4'd5, 1, 4'd3, 32'h3333_3333);
      step("R8", 4'd4, 4'd2, 0, 0, 0, 0, 0, 0);
      step("R6", 4'd4, 4'd4, 0, 0, 0, 1, 4'd5, 32'h5555_5555);
      step("R6", 4'd4, 4'd0, 0, 0, 0, 0, 0, 0);
      // R10 unmapped dispatch and lookup
      step("R10", 4'd3, 4'd1, 1, 4'd1, 4'd9, 0, 0, 0);
      step("R10", 4'd0, 4'd8, 0, 0, 0, 0, 0, 0);
      // R11 zero-tag dispatch and invalid / zero-tag broadcasts
      step("R11", 4'd8, 4'd0, 1, 4'd8, 4'd0, 0, 0, 0);
      step("R11", 4'd8, 4'd0, 1, 4'd8, 4'd6, 0, 4'd6, 32'hDEAD_0006);
      step("R11", 4'd8, 4'd8, 0, 0, 0, 0, 4'd6, 32'hDEAD_0006);
      step("R11", 4'd8, 4'd0, 0, 0, 0, 1, 4'd0, 32'hDEAD_0000);
      step("R2", 4'd8, 4'd0, 0, 0, 0, 1, 4'd6, 32'h6666_6666);
      step("R2", 4'd8, 4'd2, 0, 0, 0, 0, 0, 0);
      // Pseudo-random sweep: R2 R3 R4 R5 R6 R7 R9 R10
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] sa, sb, da, dt, ct;
         logic de, cv;
         int pick;
         sa = 4'($urandom); sb = 4'($urandom);
         if ($urandom % 4 != 0) sa = 4'(1 << ($urandom % 4)) & 4'hE;
         da = ($urandom % 3 == 0) ? 4'($urandom) : 4'(regaddr($urandom % 4));
         dt = 4'($urandom % 11);
         de = ($urandom % 3) == 0;
         cv = ($urandom % 2) == 0;
         pick = $urandom % 4;
         ct = ($urandom % 4 == 0) ? 4'($urandom) : m_tag[pick];
         step("R2 R3 R6 R7 R9 sweep", sa, sb, de, da, dt, cv, ct, $urandom);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic int regaddr(input int i);
      return (i == 0) ? 0 : (1 << i);
   endfunction
endmodule